// File: doc/BRIEF.md
# Configurable LUT Logic Cluster

This block is one logic tile of a soft, runtime-reconfigurable fabric. It holds N logic elements. Each element has a K-input lookup table, a D flip-flop behind the table, and a two-way select. The select presents either the stored flip-flop value or the live table value on the element's output. A local crossbar in front of each table input picks one signal from the tile's cluster inputs or from any element output. This lets elements feed one another, or themselves, inside the tile.

All settings arrive over a single serial chain that moves while the load enable is high. These settings are the table contents, the crossbar choices and the register-bypass bits. During loading the logic outputs are forced low and the flip-flops keep their contents. Once loading ends, the tile evaluates continuously. Its flip-flops advance on clock edges where the clock-enable is high.

A loop made of bypassed elements feeding each other combinationally is an illegal setting. The tile does not detect it.

Top module: `lut_cluster`

## Requirements
- R1: While `cfg_en` is high, every rising clock edge shifts `cfg_din` into bit 0 of a chain of N·(2^K + K·S + 1) bits, where S = ceil(log2(I+N)), and all other bits move up one place, so the first bit sent ends at the top. Element e owns the slice starting at e·(2^K+K·S+1). Within it, bit 0 is the bypass flag. Bits 1+j·S upward hold the S-bit source code for table input j. The 2^K table bits come last, table entry t at offset 1+K·S+t.
- R2: While `cfg_en` is high every bit of `lc_out` is 0.
- R3: An element's table value is the table entry whose index has bit j equal to the source chosen for table input j (input 0 is the least significant index bit).
- R4: The tile has I = K·(N+1)/2 cluster inputs. Source code c < I selects `lc_in[c]`. A code I ≤ c < I+N selects `lc_out[c−I]`. Any larger code yields constant 0.
- R5: With its bypass flag 1, an element drives its table value to its output in the same cycle. With the flag 0, it drives its flip-flop value.
- R6: A flip-flop loads its element's table value on a rising edge where `ce` is high and `cfg_en` is low. Otherwise it keeps its value, including while loading.
- R7: `rst` high at a rising edge clears every flip-flop to 0, taking priority over `ce`.
- R8: The loaded settings are kept while `cfg_en` is low, and `rst` does not alter them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high flip-flop clear |
| ce | input | 1 | Flip-flop clock-enable |
| cfg_en | input | 1 | Settings load enable; chain shifts while high |
| cfg_din | input | 1 | Serial settings bit |
| lc_in | input | I (15) | Cluster inputs |
| lc_out | output | N (4) | One output per logic element |

## Verification
The bench builds the tile with its defaults: 6-input tables and four elements. That gives 15 cluster inputs and 19 sources behind 5-bit codes, so the unused codes 19 to 31 can be exercised as constant-zero sources. With these values, the 380-bit chain is long enough to show any slicing error in the layout. With four elements, mixed registered and bypassed elements can be combined, and registered self-feedback and cross-feedback can run next to combinational paths. A behavioural model runs alongside the tile and is compared every cycle through directed and random settings, with `ce` gaps and resets in mid-run.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // width of one crossbar source code for a tile of n elements with k-input tables
  function automatic int sel_width(int k, int n);
    return $clog2(k * (n + 1) / 2 + n);
  endfunction

  // settings bits owned by one element: bypass, k source codes, 2^k table entries
  function automatic int elem_bits(int k, int sw);
    return (1 << k) + k * sw + 1;
  endfunction
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic [W-1:0] chain_q
);
  generate
    if (W > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (cfg_en) chain_q <= {chain_q[W-2:0], cfg_din};
      end
      // R1: older bits advance one place per loading edge
      a_r1_bits_advance: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> chain_q[W-1:1] == $past(chain_q[W-2:0]));
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (cfg_en) chain_q <= cfg_din;
      end
    end
  endgenerate

  // R1: serial bit enters at the bottom
  a_r1_bit_enters: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> chain_q[0] == $past(cfg_din));
  // R8: settings frozen outside loading
  a_r8_settings_kept: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(chain_q));
endmodule

// File: rtl/lc_xbar.sv
module lc_xbar #(
  parameter int NSRC = 19,
  parameter int SW   = 5
) (
  input  logic [SW-1:0]   sel,
  input  logic [NSRC-1:0] src,
  output logic            pick
);
  always_comb begin
    pick = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (sel == SW'(s)) pick = src[s];
    end
  end
endmodule

// File: rtl/lc_ble.sv
module lc_ble #(
  parameter int K    = 6,
  parameter int NSRC = 19,
  parameter int SW   = 5,
  localparam int TTB = 1 << K
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic            cfg_en,
  input  logic [TTB-1:0]  cfg_tt,
  input  logic [K*SW-1:0] cfg_sel,
  input  logic            cfg_byp,
  input  logic [NSRC-1:0] src,
  output logic            elem_out
);
  logic [K-1:0] lut_idx;
  logic         lut_val;
  logic         ff_q;

  generate
    for (genvar j = 0; j < K; j++) begin : g_pin
      lc_xbar #(.NSRC(NSRC), .SW(SW)) u_xbar (
        .sel  (cfg_sel[j*SW +: SW]),
        .src  (src),
        .pick (lut_idx[j])
      );
    end
  endgenerate

  assign lut_val = cfg_tt[lut_idx];

  always_ff @(posedge clk) begin
    if (rst)                ff_q <= 1'b0;
    else if (ce && !cfg_en) ff_q <= lut_val;
  end

  always_comb begin
    if (cfg_en)       elem_out = 1'b0;
    else if (cfg_byp) elem_out = lut_val;
    else              elem_out = ff_q;
  end

  // R7: reset clears the register
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> ff_q == 1'b0);
  // R6: enabled edge captures the table value
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (ce && !cfg_en) |=> ff_q == $past(lut_val));
  // R6: no capture without enable or while loading
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !(ce && !cfg_en) |=> $stable(ff_q));
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster #(
  parameter int K = 6,
  parameter int N = 4,
  localparam int I = K * (N + 1) / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         cfg_en,
  input  logic         cfg_din,
  input  logic [I-1:0] lc_in,
  output logic [N-1:0] lc_out
);
  localparam int NSRC = I + N;
  localparam int SW   = lc_pkg::sel_width(K, N);
  localparam int TTB  = 1 << K;
  localparam int EW   = lc_pkg::elem_bits(K, SW);
  localparam int TOT  = N * EW;
  localparam int SOFF = 1;
  localparam int TOFF = 1 + K * SW;

  logic [TOT-1:0]  chain_q;
  logic [NSRC-1:0] src_bus;

  assign src_bus = {lc_out, lc_in};

  lc_cfg_chain #(.W(TOT)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .chain_q (chain_q)
  );

  generate
    for (genvar e = 0; e < N; e++) begin : g_elem
      lc_ble #(.K(K), .NSRC(NSRC), .SW(SW)) u_ble (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .cfg_en   (cfg_en),
        .cfg_tt   (chain_q[e*EW + TOFF +: TTB]),
        .cfg_sel  (chain_q[e*EW + SOFF +: K*SW]),
        .cfg_byp  (chain_q[e*EW]),
        .src      (src_bus),
        .elem_out (lc_out[e])
      );
    end
  endgenerate

  // R2: outputs quiet while settings load
  a_r2_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> $countones(lc_out) == 0);
endmodule

// File: tb/lut_cluster_test.sv
module lut_cluster_test;
  localparam int K    = 6;
  localparam int N    = 4;
  localparam int I    = K * (N + 1) / 2;
  localparam int NS   = I + N;
  localparam int SW   = $clog2(NS);
  localparam int TTB  = 1 << K;
  localparam int EW   = TTB + K * SW + 1;
  localparam int TOT  = N * EW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic cfg_en = 1'b1;
  logic cfg_din = 1'b0;
  logic [I-1:0] lc_in = '0;
  logic [N-1:0] lc_out;

  always #10 clk = ~clk;

  lut_cluster #(.K(K), .N(N)) uut (
    .clk(clk), .rst(rst), .ce(ce), .cfg_en(cfg_en),
    .cfg_din(cfg_din), .lc_in(lc_in), .lc_out(lc_out)
  );

  // behavioural model state
  logic [TTB-1:0] m_tt [N];
  int             m_sel [N][K];
  bit             m_byp [N];
  bit             m_ff  [N];
  bit             m_nx  [N];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic bit src_val(int c, logic [N-1:0] o);
    if (c < I) return lc_in[c];
    if (c < I + N) return o[c - I];
    return 1'b0;
  endfunction

  function automatic bit lut_eval(int e, logic [N-1:0] o);
    int idx = 0;
    for (int j = 0; j < K; j++) idx = idx | (int'(src_val(m_sel[e][j], o)) << j);
    return m_tt[e][idx];
  endfunction

  task automatic step(bit r, bit c, bit ld, bit d, logic [I-1:0] in_v, string tag);
    logic [N-1:0] exp_o;
    @(negedge clk);
    rst = r; ce = c; cfg_en = ld; cfg_din = d; lc_in = in_v;
    #2;
    exp_o = '0;
    if (!ld) begin
      for (int e = 0; e < N; e++) if (!m_byp[e]) exp_o[e] = m_ff[e];
      for (int e = 0; e < N; e++) if (m_byp[e]) exp_o[e] = lut_eval(e, exp_o);
    end
    for (int e = 0; e < N; e++) m_nx[e] = lut_eval(e, exp_o);
    n_checks++;
    if (lc_out !== exp_o) begin
      n_fail++;
      $display("FAIL %s: lc_out=%b expected %b", tag, lc_out, exp_o);
    end
    @(posedge clk);
    for (int e = 0; e < N; e++) begin
      if (r) m_ff[e] = 1'b0;
      else if (c && !ld) m_ff[e] = m_nx[e];
    end
  endtask

  // R1: serialise the model's settings in the chain layout, top bit first
  task automatic load_cfg();
    bit bits [TOT];
    for (int e = 0; e < N; e++) begin
      bits[e*EW] = m_byp[e];
      for (int j = 0; j < K; j++)
        for (int b = 0; b < SW; b++) bits[e*EW + 1 + j*SW + b] = m_sel[e][j][b];
      for (int t = 0; t < TTB; t++) bits[e*EW + 1 + K*SW + t] = m_tt[e][t];
    end
    for (int i = TOT - 1; i >= 0; i--)
      step(1'b0, 1'($urandom % 2), 1'b1, bits[i], I'($urandom), "R1 R2 R6 loading");
  endtask

  task automatic random_cfg();
    for (int e = 0; e < N; e++) m_byp[e] = 1'($urandom % 2);
    for (int e = 0; e < N; e++) begin
      m_tt[e] = {$urandom, $urandom};
      for (int j = 0; j < K; j++) begin
        int r = $urandom % 10;
        if (r < 6) m_sel[e][j] = $urandom % I;
        else if (r < 9) begin
          int f = $urandom % N;
          if (m_byp[e] && m_byp[f]) m_sel[e][j] = $urandom % I;
          else m_sel[e][j] = I + f;
        end else m_sel[e][j] = NS + ($urandom % ((1 << SW) - NS));
      end
    end
  endtask

  task automatic run(int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      bit r = ($urandom % 40) == 0;
      step(r, ($urandom % 4) != 0, 1'b0, 1'b0, I'($urandom), r ? "R7 R8 reset" : tag);
    end
  endtask

  initial begin
    for (int e = 0; e < N; e++) begin
      m_ff[e] = 1'b0; m_byp[e] = 1'b0; m_tt[e] = '0;
      for (int j = 0; j < K; j++) m_sel[e][j] = 0;
    end
    // reset state with loading active: R2 R7
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0, '1, "R2 R7 reset state");

    // directed settings
    m_byp[0] = 1'b1; m_tt[0] = {$urandom, $urandom};
    for (int j = 0; j < K; j++) m_sel[0][j] = j;          // R3 plain index
    m_byp[1] = 1'b1; m_tt[1] = 64'h1;                     // R4 unmapped codes read 0
    for (int j = 0; j < K; j++) m_sel[1][j] = (j % 2) ? (1 << SW) - 1 : NS;
    m_byp[2] = 1'b0; m_tt[2] = {$urandom, $urandom};      // R5 registered, reads elem 0
    for (int j = 0; j < K; j++) m_sel[2][j] = (j == 0) ? I : 7 + j;
    m_byp[3] = 1'b0;                                      // R6 self toggle via own output
    for (int t = 0; t < TTB; t++) m_tt[3][t] = ~t[0];
    for (int j = 0; j < K; j++) m_sel[3][j] = (j == 0) ? I + 3 : NS + 1;
    load_cfg();
    step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R7 reset after load");
    for (int b = 0; b < K; b++) step(1'b0, 1'b1, 1'b0, 1'b0, I'(1 << b), "R3 R4 single input");
    step(1'b0, 1'b0, 1'b0, 1'b0, '1, "R6 ce low hold");
    step(1'b0, 1'b0, 1'b0, 1'b0, '0, "R6 ce low hold");
    run(40, "R3 R4 R5 R6 directed");

    for (int k = 0; k < 15; k++) begin
      random_cfg();
      load_cfg();
      run(60, "R3 R4 R5 R6 R8 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule